// File: doc/BRIEF.md
# Sticky Interrupt Flag Controller

This block gathers interrupt requests for four filter channels and folds them into one interrupt pin. Each channel contributes three sources: a high-threshold comparator output, a low-threshold comparator output, and a modulator clock. The modulator clock is checked by a built-in watchdog running on the system clock. Each source latches into its own sticky flag bit. A flag can be set only while the master enable and the source's own enable are both high. All twelve flags are presented on a read-data bus.

A read strobe models a read of the interrupt register. During the strobe cycle the bus shows the flag values as they stood before the read. At the clock edge that ends the strobe, each flag whose source is no longer active is cleared. A flag whose source is still active stays set. The interrupt pin is the OR of all twelve flags, and a polarity bit selects whether the pin is active-high or active-low.

All enable and polarity inputs are plain register-style levels. The block has no streaming data path, so it has no valid/ready handshake. Reads carry no back-pressure: every strobe cycle is one complete read.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Flag layout on `rd_data`: bit n holds the high-comparator flag of channel n, bit 4+n holds the low-comparator flag, and bit 8+n holds the modulator-fail flag (n = 0..3).
- R2: A comparator flag is set only when its source is high at a clock edge while `master_en` and the source's own enable are both high.
- R3: Once set, a flag stays set after its source returns low, until a read clears it.
- R4: When a read happens, a flag whose source is low in the read cycle is cleared at the end of that cycle. A flag whose source is still high stays set.
- R5: During a read-strobe cycle, `rd_data` shows the flag values from before the read. The cleared values appear in the following cycle.
- R6: A source that is active and enabled during the read cycle leaves its flag set after the read, even if the flag was clear before the read.
- R7: A modulator clock that shows no synchronized rising edge for 64 system clocks counts as failed. Its fail flag is set only when `fail_en` for that channel and `master_en` are both high.
- R8: A read does not clear a modulator-fail flag while the clock is still failing. A read after the clock has recovered clears it.
- R9: `irq_out` is active whenever any of the twelve flags is set. With `irq_pol`=0 the active level is 1; with `irq_pol`=1 the active level is 0.
- R10: Reset clears all flags and all watchdog counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_hi | input | 4 | High-threshold comparator outputs, one per channel |
| cmp_lo | input | 4 | Low-threshold comparator outputs, one per channel |
| mod_clk | input | 4 | Modulator clocks, asynchronous to `clk` |
| master_en | input | 1 | Master interrupt enable |
| hi_en | input | 4 | Per-channel enable for the high-comparator flags |
| lo_en | input | 4 | Per-channel enable for the low-comparator flags |
| fail_en | input | 4 | Per-channel enable for the modulator-fail flags |
| irq_pol | input | 1 | Interrupt polarity: 0 = active-high, 1 = active-low |
| rd_stb | input | 1 | Interrupt-register read strobe, one cycle per read |
| rd_data | output | 12 | Current flag values, laid out as in R1 |
| irq_out | output | 1 | Interrupt output |

## Verification
On every cycle, the assertions check the following:
- No comparator or fail flag rises without the enables that permit it.
- No flag falls except in the cycle after a read.
- A read never clears a comparator flag whose source was still active.
- An empty flag set always leaves the interrupt pin at its inactive level.

The bench scenarios cover the behaviours that depend on ordering and timing:
- Reads return the values from before the read.
- A source active in the read cycle keeps its flag set.
- A stopped modulator clock raises its flag only after the 64-cycle window.
- A fail flag survives a read until its clock runs again.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned SYNC_DEPTH  = 2;
  localparam int unsigned FLAG_GROUPS = 3;
  localparam int unsigned GRP_HI      = 0;
  localparam int unsigned GRP_LO      = 1;
  localparam int unsigned GRP_FAIL    = 2;
endpackage

// File: rtl/irq_clk_wdog.sv
module irq_clk_wdog #(
  parameter int unsigned LIMIT = 64,
  parameter int unsigned SYNC  = irq_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_clk,
  output logic failed
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            edge_seen;
  logic [CW-1:0]   cnt_q;

  // synchronizer chain into the system clock domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], mod_clk};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign edge_seen = sync_q[SYNC-1] & ~prev_q;

  // cycles since the last rising edge, saturating at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (edge_seen) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign failed = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] en,
  input  logic         master_en,
  input  logic         rd_stb,
  output logic [W-1:0] flags
);
  logic [W-1:0] flag_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic set_i;
    logic clr_i;
    assign set_i = src[i] & en[i] & master_en;
    assign clr_i = rd_stb & ~src[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q[i] <= 1'b0;
      else if (set_i) flag_q[i] <= 1'b1;   // set has priority over read-clear
      else if (clr_i) flag_q[i] <= 1'b0;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned WDOG_LIMIT = 64
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_CH-1:0]                    cmp_hi,
  input  logic [NUM_CH-1:0]                    cmp_lo,
  input  logic [NUM_CH-1:0]                    mod_clk,
  input  logic                                 master_en,
  input  logic [NUM_CH-1:0]                    hi_en,
  input  logic [NUM_CH-1:0]                    lo_en,
  input  logic [NUM_CH-1:0]                    fail_en,
  input  logic                                 irq_pol,
  input  logic                                 rd_stb,
  output logic [irq_pkg::FLAG_GROUPS*NUM_CH-1:0] rd_data,
  output logic                                 irq_out
);
  localparam int unsigned NF = irq_pkg::FLAG_GROUPS * NUM_CH;

  logic [NUM_CH-1:0] mod_fail;
  logic [NF-1:0]     src_all;
  logic [NF-1:0]     en_all;
  logic [NF-1:0]     flags;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_wdog
    irq_clk_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .mod_clk (mod_clk[c]),
      .failed  (mod_fail[c])
    );
  end

  assign src_all[irq_pkg::GRP_HI*NUM_CH   +: NUM_CH] = cmp_hi;
  assign src_all[irq_pkg::GRP_LO*NUM_CH   +: NUM_CH] = cmp_lo;
  assign src_all[irq_pkg::GRP_FAIL*NUM_CH +: NUM_CH] = mod_fail;
  assign en_all [irq_pkg::GRP_HI*NUM_CH   +: NUM_CH] = hi_en;
  assign en_all [irq_pkg::GRP_LO*NUM_CH   +: NUM_CH] = lo_en;
  assign en_all [irq_pkg::GRP_FAIL*NUM_CH +: NUM_CH] = fail_en;

  irq_flag_bank #(.W(NF)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src_all),
    .en        (en_all),
    .master_en (master_en),
    .rd_stb    (rd_stb),
    .flags     (flags)
  );

  assign rd_data = flags;
  assign irq_out = (|flags) ^ irq_pol;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_CH-1:0]     cmp_hi,
  input logic [NUM_CH-1:0]     cmp_lo,
  input logic                  master_en,
  input logic [NUM_CH-1:0]     hi_en,
  input logic [NUM_CH-1:0]     lo_en,
  input logic [NUM_CH-1:0]     fail_en,
  input logic                  irq_pol,
  input logic                  rd_stb,
  input logic [3*NUM_CH-1:0]   rd_data,
  input logic                  irq_out
);
  logic [NUM_CH-1:0] fhi, flo, ffl;
  assign fhi = rd_data[0        +: NUM_CH];
  assign flo = rd_data[NUM_CH   +: NUM_CH];
  assign ffl = rd_data[2*NUM_CH +: NUM_CH];

  p_hi_set_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((fhi & ~$past(fhi) & ~($past(hi_en) & {NUM_CH{$past(master_en)}})) == '0));

  p_lo_set_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((flo & ~$past(flo) & ~($past(lo_en) & {NUM_CH{$past(master_en)}})) == '0));

  p_fail_set_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ffl & ~$past(ffl) & ~($past(fail_en) & {NUM_CH{$past(master_en)}})) == '0));

  p_fall_only_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(rd_data) & ~rd_data)) |-> $past(rd_stb));

  p_active_survives_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(fhi) & $past(cmp_hi)) & ~fhi) == '0) &&
    ((($past(flo) & $past(cmp_lo)) & ~flo) == '0));

  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == '0) |-> (irq_out == irq_pol));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_hi    (cmp_hi),
  .cmp_lo    (cmp_lo),
  .master_en (master_en),
  .hi_en     (hi_en),
  .lo_en     (lo_en),
  .fail_en   (fail_en),
  .irq_pol   (irq_pol),
  .rd_stb    (rd_stb),
  .rd_data   (rd_data),
  .irq_out   (irq_out)
);

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmp_hi = '0, cmp_lo = '0, mod_clk = '0;
  logic        master_en = 1'b0;
  logic [3:0]  hi_en = '0, lo_en = '0, fail_en = '0;
  logic        irq_pol = 1'b0, rd_stb = 1'b0;
  logic [11:0] rd_data;
  logic        irq_out;
  logic [3:0]  mod_run = 4'hF;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  always begin
    repeat (4) @(posedge clk);
    mod_clk <= mod_clk ^ mod_run;
  end

  irq_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .mod_clk(mod_clk),
    .master_en(master_en), .hi_en(hi_en), .lo_en(lo_en), .fail_en(fail_en),
    .irq_pol(irq_pol), .rd_stb(rd_stb), .rd_data(rd_data), .irq_out(irq_out)
  );

  // {master, hi_en, lo_en, cmp_hi, cmp_lo, expected {lo,hi} flags}
  localparam logic [24:0] VEC [6] = '{
    {1'b1, 4'hF, 4'hF, 4'h1, 4'h0, 8'h01},
    {1'b1, 4'hF, 4'hF, 4'h0, 4'hA, 8'hA0},
    {1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 8'h00},
    {1'b1, 4'h5, 4'h0, 4'hF, 4'hF, 8'h05},
    {1'b1, 4'h0, 4'hC, 4'hF, 4'h6, 8'h40},
    {1'b1, 4'hF, 4'hF, 4'h8, 4'h1, 8'h18}
  };

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    step();
    rd_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    chk("R10 reset flags", 32'(rd_data), 32'h0);
    chk("R9 reset irq idle high-active", 32'(irq_out), 32'h0);

    // vector table: comparator latching, enables, layout
    for (int i = 0; i < 6; i++) begin
      master_en = VEC[i][24];
      hi_en = VEC[i][23:20];
      lo_en = VEC[i][19:16];
      cmp_hi = VEC[i][15:12];
      cmp_lo = VEC[i][11:8];
      step();
      cmp_hi = '0; cmp_lo = '0;
      step();
      chk($sformatf("R1 R2 R3 vector %0d", i), 32'(rd_data), 32'(VEC[i][7:0]));
      do_read();
      chk($sformatf("R4 vector %0d cleared", i), 32'(rd_data), 32'h0);
    end

    master_en = 1'b1; hi_en = 4'hF; lo_en = 4'hF;

    // R4: active source survives the read
    cmp_hi = 4'h2;
    step();
    do_read();
    chk("R4 active source keeps flag", 32'(rd_data), 32'h002);
    chk("R9 irq active high", 32'(irq_out), 32'h1);
    cmp_hi = '0;
    step();
    do_read();
    chk("R4 inactive source clears", 32'(rd_data), 32'h0);

    // R5: pre-clear value visible during the read cycle
    cmp_lo = 4'h2;
    step();
    cmp_lo = '0;
    rd_stb = 1'b1;
    #1;
    chk("R5 pre-clear value during read", 32'(rd_data), 32'h020);
    step();
    rd_stb = 1'b0;
    chk("R5 cleared after read", 32'(rd_data), 32'h0);

    // R6: source rising in the read cycle keeps its flag
    cmp_hi = 4'h4;
    rd_stb = 1'b1;
    step();
    rd_stb = 1'b0; cmp_hi = '0;
    chk("R6 set wins over clear", 32'(rd_data), 32'h004);
    do_read();
    chk("R6 later read clears", 32'(rd_data), 32'h0);

    // R7: watchdog on channel 2 enabled, channel 1 disabled
    fail_en = 4'b0100;
    mod_run = 4'b1001;
    step(50);
    chk("R7 no fail before window", 32'(rd_data), 32'h0);
    step(50);
    chk("R7 fail flag after window", 32'(rd_data), 32'h400);
    irq_pol = 1'b1;
    #1;
    chk("R9 active-low with fail flag", 32'(irq_out), 32'h0);
    irq_pol = 1'b0;

    // R8: read while still failing keeps flag
    do_read();
    chk("R8 fail held while clock stopped", 32'(rd_data), 32'h400);
    mod_run = 4'hF;
    step(20);
    do_read();
    chk("R8 fail cleared after recovery", 32'(rd_data), 32'h0);
    irq_pol = 1'b1;
    #1;
    chk("R9 idle level active-low", 32'(irq_out), 32'h1);
    irq_pol = 1'b0;

    // R10: reset mid-run clears flags and watchdog count
    cmp_hi = 4'h8;
    step();
    cmp_hi = '0;
    mod_run = 4'b1011;
    step(40);
    rst_n = 1'b0;
    step(2);
    chk("R10 reset clears flags", 32'(rd_data), 32'h0);
    rst_n = 1'b1;
    step(50);
    chk("R10 watchdog count restarted", 32'(rd_data), 32'h0);
    step(30);
    chk("R7 fail after restarted window", 32'(rd_data), 32'h400);
    mod_run = 4'hF;
    step(20);
    do_read();

    finish_run();
  end
endmodule